// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block decides where a 32-bit processor fetches next. It holds the current program counter and takes four inputs for each retiring instruction: a decoded control-flow class, the two register operands, a 16-bit branch displacement and a 26-bit jump index. From these it forms the sequential address, evaluates the branch predicate, builds the PC-relative, region-relative or register-indirect target, and picks the winner. For the linking jump forms it also gives the return address and the register that receives it.

An exception redirect has the highest priority. When it is raised, the PC loads a supplied vector and the link write and the misalignment flag are both suppressed. A register-indirect target whose two low bits are not zero raises a fetch address-error flag, and the PC still follows the target. The PC advances only on a cycle where `step` is high, or when a redirect is raised. Delay slots, prediction and the fetch itself belong to other blocks.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, and after reset is released, `pc_q` equals the parameter `RESET_PC` (default 32'h0000_1000) until the first update.
- R2: For class code 0 (sequential), and for the unused codes 11 to 15, `pc_nxt` is `pc_q`+4. `pc_q` takes `pc_nxt` at a clock edge where `step` is 1. It holds its value when both `step` and `exc_req` are 0.
- R3: For a taken branch (codes 1 to 6), `pc_nxt` is `pc_q`+4 plus `imm16` sign-extended and multiplied by 4. For a branch that is not taken, `pc_nxt` is `pc_q`+4. `taken` is 1 exactly when the branch is taken.
- R4: Code 1 is taken when `rs_val` equals `rt_val`. Code 2 is taken when they differ.
- R5: `rs_val` is read as two's complement for these codes. Code 3 is taken when rs ≥ 0, code 4 when rs > 0, code 5 when rs ≤ 0, and code 6 when rs < 0.
- R6: For codes 7 (jump) and 8 (jump-and-link), `pc_nxt` is {`pc_q`[31:28], `jidx`, 2'b00} and `taken` is 1.
- R7: For codes 9 (jump-register) and 10 (jump-and-link-register), `pc_nxt` equals `rs_val` and `taken` is 1.
- R8: Code 8 drives `link_we`=1, `link_idx`=31 and `link_val`=`pc_q`+4.
- R9: Code 10 drives `link_idx`=`rd_idx` and `link_val`=`pc_q`+4. It drives `link_we`=1 only when `rd_idx` is not 0. No other code ever writes a link.
- R10: When `exc_req` is 1, `pc_nxt` is `exc_vec` and `pc_q` loads it at the next edge whatever the value of `step`. `link_we`, `taken` and `fetch_misal` are 0.
- R11: For codes 9 and 10 without `exc_req`, `fetch_misal` is 1 exactly when `rs_val`[1:0] is not 0. For all other codes it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Retire the current instruction and advance the PC |
| kind | input | 4 | Control-flow class code (see R2 to R9) |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| imm16 | input | 16 | Branch displacement in words |
| jidx | input | 26 | Jump index |
| rd_idx | input | 5 | Link destination for jump-and-link-register |
| exc_req | input | 1 | Exception redirect request |
| exc_vec | input | 32 | Exception redirect address |
| pc_q | output | 32 | Current PC |
| pc_nxt | output | 32 | Selected next PC |
| taken | output | 1 | A control transfer other than sequential was chosen |
| link_we | output | 1 | Link write enable |
| link_idx | output | 5 | Link destination register |
| link_val | output | 32 | Return address |
| fetch_misal | output | 1 | Register target not word aligned |

## Verification
Each sign test is driven with zero, a small positive value, a negative value and the most negative value. This separates ≥ from > and ≤ from <, and it catches a predicate that compares the operand as unsigned. The branch equality codes are tried with equal and unequal pairs, and the offset is given a negative value, so that a missing sign extension or a missing shift moves the target. The direct jump starts from a PC whose upper nibble is not zero, and the register jumps use both aligned and misaligned targets with a zero and a nonzero link register. An exception raised on a linking jump shows whether the redirect wins and whether it masks the side outputs.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN = 32;
  localparam int LINK_REG = 31;

  typedef enum logic [3:0] {
    CF_SEQ  = 4'd0,
    CF_BEQ  = 4'd1,
    CF_BNE  = 4'd2,
    CF_BGEZ = 4'd3,
    CF_BGTZ = 4'd4,
    CF_BLEZ = 4'd5,
    CF_BLTZ = 4'd6,
    CF_J    = 4'd7,
    CF_JAL  = 4'd8,
    CF_JR   = 4'd9,
    CF_JALR = 4'd10
  } cf_kind_e;

  function automatic logic [XLEN-1:0] f_seq(input logic [XLEN-1:0] pc);
    return pc + XLEN'(4);
  endfunction

  function automatic logic [XLEN-1:0] f_rel(input logic [XLEN-1:0] pc,
                                            input logic [15:0] disp);
    logic [XLEN-1:0] ext;
    ext = {{(XLEN-18){disp[15]}}, disp, 2'b00};
    return f_seq(pc) + ext;
  endfunction

  function automatic logic [XLEN-1:0] f_region(input logic [XLEN-1:0] pc,
                                               input logic [25:0] idx);
    return {pc[XLEN-1:XLEN-4], idx, 2'b00};
  endfunction
endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
(
  input  logic [3:0]      kind,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            br_take,
  output logic            is_branch
);
  logic neg, zero, same;
  assign neg  = a[XLEN-1];
  assign zero = (a == '0);
  assign same = (a == b);

  always_comb begin
    br_take   = 1'b0;
    is_branch = 1'b1;
    case (cf_kind_e'(kind))
      CF_BEQ:  br_take = same;
      CF_BNE:  br_take = !same;
      CF_BGEZ: br_take = !neg;
      CF_BGTZ: br_take = !neg && !zero;
      CF_BLEZ: br_take = neg || zero;
      CF_BLTZ: br_take = neg;
      default: is_branch = 1'b0;
    endcase
  end

  always_comb begin
    if (is_branch && kind == CF_BLTZ)
      a_ltz_r5: assert (br_take == $signed(a) < 0);
    if (is_branch && kind == CF_BGTZ)
      a_gtz_r5: assert (br_take == $signed(a) > 0);
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  logic [3:0]      kind,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rs,
  input  logic [15:0]     disp,
  input  logic [25:0]     idx,
  input  logic            br_take,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] tgt,
  output logic            xfer,
  output logic            reg_tgt
);
  assign seq_pc = f_seq(pc);

  always_comb begin
    tgt     = seq_pc;
    xfer    = 1'b0;
    reg_tgt = 1'b0;
    case (cf_kind_e'(kind))
      CF_BEQ, CF_BNE, CF_BGEZ, CF_BGTZ, CF_BLEZ, CF_BLTZ: begin
        xfer = br_take;
        if (br_take) tgt = f_rel(pc, disp);
      end
      CF_J, CF_JAL: begin
        xfer = 1'b1;
        tgt  = f_region(pc, idx);
      end
      CF_JR, CF_JALR: begin
        xfer    = 1'b1;
        reg_tgt = 1'b1;
        tgt     = rs;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/npc_link.sv
module npc_link
  import npc_pkg::*;
(
  input  logic [3:0]      kind,
  input  logic [4:0]      rd,
  input  logic [XLEN-1:0] seq_pc,
  output logic            we,
  output logic [4:0]      idx,
  output logic [XLEN-1:0] val
);
  assign val = seq_pc;

  always_comb begin
    we  = 1'b0;
    idx = '0;
    case (cf_kind_e'(kind))
      CF_JAL: begin
        we  = 1'b1;
        idx = 5'(LINK_REG);
      end
      CF_JALR: begin
        idx = rd;
        we  = (rd != '0);
      end
      default: ;
    endcase
  end

  always_comb begin
    if (we) a_nonzero_dst_r9: assert (idx != '0);
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic [3:0]  kind,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  input  logic [15:0] imm16,
  input  logic [25:0] jidx,
  input  logic [4:0]  rd_idx,
  input  logic        exc_req,
  input  logic [31:0] exc_vec,
  output logic [31:0] pc_q,
  output logic [31:0] pc_nxt,
  output logic        taken,
  output logic        link_we,
  output logic [4:0]  link_idx,
  output logic [31:0] link_val,
  output logic        fetch_misal
);
  logic            br_take, is_branch, xfer, reg_tgt, lk_we;
  logic [XLEN-1:0] seq_pc, tgt;
  logic            upd;

  npc_cond u_cond (
    .kind(kind), .a(rs_val), .b(rt_val),
    .br_take(br_take), .is_branch(is_branch)
  );

  npc_target u_tgt (
    .kind(kind), .pc(pc_q), .rs(rs_val), .disp(imm16), .idx(jidx),
    .br_take(br_take), .seq_pc(seq_pc), .tgt(tgt), .xfer(xfer),
    .reg_tgt(reg_tgt)
  );

  npc_link u_link (
    .kind(kind), .rd(rd_idx), .seq_pc(seq_pc),
    .we(lk_we), .idx(link_idx), .val(link_val)
  );

  assign pc_nxt      = exc_req ? exc_vec : tgt;
  assign taken       = xfer && !exc_req;
  assign link_we     = lk_we && !exc_req;
  assign fetch_misal = reg_tgt && !exc_req && (rs_val[1:0] != 2'b00);
  assign upd         = step || exc_req;

  always_ff @(posedge clk) begin
    if (!rst_n)   pc_q <= RESET_PC;
    else if (upd) pc_q <= pc_nxt;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !exc_req) |=> $stable(pc_q));
  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !exc_req) |=> pc_q == $past(pc_nxt));
  p_redirect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> pc_q == $past(exc_vec));
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> !link_we && !fetch_misal && !taken);
  p_misal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_misal |-> pc_nxt[1:0] != 2'b00);
  p_notaken_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && !br_take && !exc_req) |-> pc_nxt == seq_pc && !taken);
endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;
  localparam logic [31:0] RPC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [3:0]  kind = 4'd0;
  logic [31:0] rs_val = '0, rt_val = '0, exc_vec = '0;
  logic [15:0] imm16 = '0;
  logic [25:0] jidx = '0;
  logic [4:0]  rd_idx = '0;
  logic        exc_req = 1'b0;
  logic [31:0] pc_q, pc_nxt, link_val;
  logic        taken, link_we, fetch_misal;
  logic [4:0]  link_idx;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  npc_unit #(.RESET_PC(RPC)) i_npc_unit (
    .clk(clk), .rst_n(rst_n), .step(step), .kind(kind), .rs_val(rs_val),
    .rt_val(rt_val), .imm16(imm16), .jidx(jidx), .rd_idx(rd_idx),
    .exc_req(exc_req), .exc_vec(exc_vec), .pc_q(pc_q), .pc_nxt(pc_nxt),
    .taken(taken), .link_we(link_we), .link_idx(link_idx),
    .link_val(link_val), .fetch_misal(fetch_misal)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] rel_exp(input logic [31:0] pc, input logic [15:0] d);
    return pc + 32'd4 + 32'($signed(d)) * 32'd4;
  endfunction

  task automatic load_pc(input logic [31:0] v);
    @(negedge clk);
    exc_req = 1'b1; exc_vec = v; step = 1'b0;
    @(negedge clk);
    exc_req = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset pc", pc_q, RPC);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc after release", pc_q, RPC);
  endtask

  task automatic t_seq;
    kind = 4'd0;
    #1 chk("R2 seq nxt", pc_nxt, RPC + 4);
    @(negedge clk); chk("R2 hold without step", pc_q, RPC);
    step = 1'b1;
    @(negedge clk); step = 1'b0;
    chk("R2 step advance", pc_q, RPC + 4);
    kind = 4'd13;
    #1 chk("R2 unused code seq", pc_nxt, RPC + 8);
    chk("R2 unused code no taken", 32'(taken), 0);
  endtask

  task automatic t_eq;
    load_pc(32'h0000_4000);
    kind = 4'd1; rs_val = 32'h55; rt_val = 32'h55; imm16 = 16'hFFF0;
    #1 chk("R4 beq equal taken", pc_nxt, rel_exp(32'h4000, 16'hFFF0));
    chk("R3 taken flag", 32'(taken), 1);
    rt_val = 32'h56;
    #1 chk("R4 beq unequal", pc_nxt, 32'h4004);
    chk("R3 not taken flag", 32'(taken), 0);
    kind = 4'd2; imm16 = 16'h0010;
    #1 chk("R4 bne unequal taken", pc_nxt, 32'h4004 + 32'h40);
    rt_val = 32'h55;
    #1 chk("R4 bne equal", pc_nxt, 32'h4004);
  endtask

  task automatic t_sign;
    logic [31:0] vals [4];
    logic [3:0]  exp_take [4];
    vals[0] = 32'h0; vals[1] = 32'h7; vals[2] = 32'hFFFF_FFF9; vals[3] = 32'h8000_0000;
    exp_take[3] = 4'b1100; exp_take[4-4] = 4'b0000;
    imm16 = 16'h0002;
    for (int v = 0; v < 4; v++) begin
      for (int c = 3; c <= 6; c++) begin
        logic t;
        logic signed [31:0] s;
        s = $signed(vals[v]);
        case (c)
          3: t = (s >= 0);
          4: t = (s > 0);
          5: t = (s <= 0);
          default: t = (s < 0);
        endcase
        kind = 4'(c); rs_val = vals[v];
        #1 chk($sformatf("R5 code %0d rs %h", c, vals[v]), pc_nxt,
               t ? rel_exp(32'h4000, 16'h0002) : 32'h4004);
      end
    end
  endtask

  task automatic t_jump;
    load_pc(32'hA000_0100);
    kind = 4'd7; jidx = 26'h123_4567;
    #1 chk("R6 jump target", pc_nxt, {4'hA, 26'h123_4567, 2'b00});
    chk("R6 jump no link", 32'(link_we), 0);
    kind = 4'd8;
    #1 chk("R6 jal target", pc_nxt, {4'hA, 26'h123_4567, 2'b00});
    chk("R8 jal we", 32'(link_we), 1);
    chk("R8 jal idx", 32'(link_idx), 31);
    chk("R8 jal val", link_val, 32'hA000_0104);
    step = 1'b1;
    @(negedge clk); step = 1'b0;
    chk("R6 pc after jal", pc_q, {4'hA, 26'h123_4567, 2'b00});
  endtask

  task automatic t_jreg;
    load_pc(32'h0000_2000);
    kind = 4'd9; rs_val = 32'h0040_0010;
    #1 chk("R7 jr target", pc_nxt, 32'h0040_0010);
    chk("R11 aligned no flag", 32'(fetch_misal), 0);
    rs_val = 32'h0040_0012;
    #1 chk("R11 misaligned flag", 32'(fetch_misal), 1);
    kind = 4'd10; rs_val = 32'h0050_0000; rd_idx = 5'd5;
    #1 chk("R7 jalr target", pc_nxt, 32'h0050_0000);
    chk("R9 jalr we", 32'(link_we), 1);
    chk("R9 jalr idx", 32'(link_idx), 5);
    chk("R9 jalr val", link_val, 32'h2004);
    rd_idx = 5'd0;
    #1 chk("R9 jalr rd0 discarded", 32'(link_we), 0);
    kind = 4'd1; rs_val = 32'h1; rt_val = 32'h2;
    #1 chk("R11 branch no flag", 32'(fetch_misal), 0);
  endtask

  task automatic t_exc;
    @(negedge clk);
    kind = 4'd10; rs_val = 32'h0000_0003; rd_idx = 5'd9;
    exc_req = 1'b1; exc_vec = 32'h8000_0180;
    #1 chk("R10 nxt is vector", pc_nxt, 32'h8000_0180);
    chk("R10 link masked", 32'(link_we), 0);
    chk("R10 misal masked", 32'(fetch_misal), 0);
    @(negedge clk); exc_req = 1'b0; kind = 4'd0;
    chk("R10 pc loaded without step", pc_q, 32'h8000_0180);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_seq();
    t_eq();
    t_sign();
    t_jump();
    t_jreg();
    t_exc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule